// File: doc/BRIEF.md
# Signed Successive-Approximation Conversion Sequencer

This block runs the digital half of a sign-plus-magnitude successive-approximation conversion. A single-cycle start request launches a conversion. The block first selects a comparison against ground to find the polarity of the held input. It then walks a trial code through a DAC from the top bit to the bottom bit and keeps or drops each bit according to a one-bit comparator input that it samples every clock.

When the last bit is settled, the sign and magnitude are copied into a result register. Completion is reported twice, on a high-active done flag and on a low-active interrupt line. The surrounding system supplies the analog DAC and comparator. The comparator input is high when the held input lies above the level that is currently selected: ground during the polarity step, or the DAC level for the magnitude code during the trials.

Top module: `sar_sign_ctrl`

## Requirements
- R1: On the clock after a start is accepted, `gnd_sel_o` is high for exactly one cycle and `dac_code_o` is zero during that cycle.
- R2: The sign bit captured in the polarity cycle is 0 when `cmp_i` is high and 1 when it is low. It appears at bit 12 of `result_o`.
- R3: In the cycle that follows the polarity cycle, `dac_code_o` is 0x800 (the top bit alone set).
- R4: During each trial, a trial bit keeps its value 1 only when `cmp_i` is high in that cycle, and is otherwise cleared. The next lower bit is then set for the following trial, so the code in trial k (k = 0..11) holds the settled upper bits, bit 11-k set, and the lower bits zero.
- R5: The 12 trials run from bit 11 down to bit 0. `result_o`, `eoc_o` (goes high) and `irq_n_o` (goes low) all change on the 13th rising edge after the edge that accepted the start.
- R6: On the edge that accepts a start, `eoc_o` goes low and `irq_n_o` goes high.
- R7: A start that arrives while a conversion is running has no effect. The running conversion keeps its timing and its result, and `result_o` holds its earlier value until that conversion completes.
- R8: Synchronous reset gives `eoc_o`=0, `irq_n_o`=1, `result_o`=0, `gnd_sel_o`=0 and `dac_code_o`=0.
- R9: When idle after a completion, `eoc_o`, `irq_n_o` and `result_o` keep their values until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator: held input above the selected level |
| dac_code_o | output | 12 | Trial code to the DAC |
| gnd_sel_o | output | 1 | Compare against ground (polarity step) |
| result_o | output | 13 | Latched {sign, magnitude} |
| irq_n_o | output | 1 | Completion interrupt, low active |
| eoc_o | output | 1 | Completion flag, high active |

## Verification
The hardest state to reach from the ports is a second start request landing in the middle of the bit trials while an older result is still on display. The directed stimulus first completes a conversion with one input value and then launches a conversion with a different value. Halfway through that search it pulses start again, and it checks at each step that the old result holds, that completion still arrives on the 13th edge, and that the new magnitude is correct. A behavioural comparator in the bench compares the absolute value of a signed input with the live DAC code, so the code sequence is checked trial by trial for negative, zero and full-scale inputs.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned DEF_MAG_W = 12;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SIGN  = 2'd1,
        PH_TRIAL = 2'd2
    } phase_e;

    // per-cycle strobes from the sequencer to the datapath
    typedef struct packed {
        logic launch;     // start accepted this cycle
        logic take_sign;  // polarity step in progress
        logic step;       // magnitude trial in progress
        logic finish;     // last trial in progress
    } seq_ctl_t;

    function automatic int unsigned idx_bits(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int unsigned MAG_W = DEF_MAG_W,
    parameter int unsigned IDX_W = idx_bits(MAG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output seq_ctl_t         ctl_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             gnd_sel_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAG_W - 1);

    phase_e           phase;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE:  if (start_i) phase <= PH_SIGN;
                PH_SIGN: begin
                    phase <= PH_TRIAL;
                    idx   <= LAST_IDX;
                end
                PH_TRIAL: begin
                    if (idx == '0) phase <= PH_IDLE;
                    else           idx   <= idx - 1'b1;
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.launch    = (phase == PH_IDLE) && start_i;
        ctl_o.take_sign = (phase == PH_SIGN);
        ctl_o.step      = (phase == PH_TRIAL);
        ctl_o.finish    = (phase == PH_TRIAL) && (idx == '0);
    end

    assign idx_o     = idx;
    assign gnd_sel_o = (phase == PH_SIGN);

    // R1: the polarity step always leads into the top trial
    p_sign_to_top_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGN) |=> (phase == PH_TRIAL) && (idx == LAST_IDX));

    // R5: the trial index never leaves the magnitude range
    p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL) |-> (idx <= LAST_IDX));

    // R7: a request inside a conversion does not restart it
    p_busy_ignores_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_TRIAL && idx != '0 && start_i) |=> (phase == PH_TRIAL));

endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int unsigned MAG_W = 12,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic             take_sign_i,
    input  logic             step_i,
    input  logic             cmp_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAG_W-1:0] code_o,
    output logic [MAG_W-1:0] mag_next_o,
    output logic             sign_o
);

    localparam logic [MAG_W-1:0] TOP_BIT = {1'b1, {(MAG_W-1){1'b0}}};

    logic [MAG_W-1:0] code;
    logic             sign_r;

    // settle the current bit from the comparator, arm the next one
    always_comb begin
        mag_next_o        = code;
        mag_next_o[idx_i] = cmp_i;
        if (idx_i != '0) mag_next_o[idx_i - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= '0;
            sign_r <= 1'b0;
        end else if (launch_i) begin
            code   <= '0;
        end else if (take_sign_i) begin
            sign_r <= ~cmp_i;
            code   <= TOP_BIT;
        end else if (step_i) begin
            code   <= mag_next_o;
        end
    end

    assign code_o = code;
    assign sign_o = sign_r;

    // R2: polarity is taken from the ground comparison
    p_sign_capture_r2: assert property (@(posedge clk) disable iff (rst)
        take_sign_i |=> (sign_o == !$past(cmp_i)));

    // R4: each tried bit ends equal to the comparator decision
    p_keep_bit_r4: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (code_o[$past(idx_i)] == $past(cmp_i)));

endmodule

// File: rtl/sar_latch.sv
module sar_latch #(
    parameter int unsigned MAG_W = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           launch_i,
    input  logic           finish_i,
    input  logic           sign_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W:0] result_o,
    output logic           eoc_o,
    output logic           irq_n_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            eoc_o    <= 1'b0;
            irq_n_o  <= 1'b1;
        end else if (launch_i) begin
            eoc_o    <= 1'b0;
            irq_n_o  <= 1'b1;
        end else if (finish_i) begin
            result_o <= {sign_i, mag_i};
            eoc_o    <= 1'b1;
            irq_n_o  <= 1'b0;
        end
    end

    // R6: flags withdrawn on acceptance
    p_launch_flags_r6: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> (!eoc_o && irq_n_o));

    // R5: both completion indications on the finishing edge
    p_done_flags_r5: assert property (@(posedge clk) disable iff (rst)
        finish_i |=> (eoc_o && !irq_n_o));

    // R7 / R9: result moves only on completion
    p_hold_result_r7: assert property (@(posedge clk) disable iff (rst)
        !finish_i |=> $stable(result_o));

endmodule

// File: rtl/sar_sign_ctrl.sv
module sar_sign_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned MAG_W = DEF_MAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [MAG_W-1:0] dac_code_o,
    output logic             gnd_sel_o,
    output logic [MAG_W:0]   result_o,
    output logic             irq_n_o,
    output logic             eoc_o
);

    localparam int unsigned      IDX_W   = idx_bits(MAG_W);
    localparam int unsigned      CNT_W   = $clog2(MAG_W + 1) + 1;
    localparam logic [MAG_W-1:0] TOP_BIT = {1'b1, {(MAG_W-1){1'b0}}};

    seq_ctl_t         ctl;
    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] mag_next;
    logic             sign_bit;

    sar_seq #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .ctl_o     (ctl),
        .idx_o     (idx),
        .gnd_sel_o (gnd_sel_o)
    );

    sar_trial #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_trial (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (ctl.launch),
        .take_sign_i (ctl.take_sign),
        .step_i      (ctl.step),
        .cmp_i       (cmp_i),
        .idx_i       (idx),
        .code_o      (dac_code_o),
        .mag_next_o  (mag_next),
        .sign_o      (sign_bit)
    );

    sar_latch #(.MAG_W(MAG_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .launch_i (ctl.launch),
        .finish_i (ctl.finish),
        .sign_i   (sign_bit),
        .mag_i    (mag_next),
        .result_o (result_o),
        .eoc_o    (eoc_o),
        .irq_n_o  (irq_n_o)
    );

    // cycles elapsed since the accepting edge, for the latency check
    logic [CNT_W-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst || ctl.launch) lat_cnt <= '0;
        else if (ctl.take_sign || ctl.step) lat_cnt <= lat_cnt + 1'b1;
    end

    // R1: the DAC is parked at zero during the ground comparison
    p_gnd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        gnd_sel_o |-> (dac_code_o == '0));

    // R3: first magnitude trial is the top bit alone
    p_top_trial_r3: assert property (@(posedge clk) disable iff (rst)
        gnd_sel_o |=> (dac_code_o == TOP_BIT));

    // R5: completion falls on the last of MAG_W trials
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.finish |-> (lat_cnt == CNT_W'(MAG_W)));

    // R5: the two completion outputs stay complementary
    p_flag_pair_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (eoc_o != irq_n_o));

endmodule

// File: tb/test_sar_sign_ctrl.sv
module test_sar_sign_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cmp;
    logic [11:0] dac;
    logic        gnd_sel;
    logic [12:0] result;
    logic        irq_n;
    logic        eoc;

    int vin;
    int mag;
    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sar_sign_ctrl i_sar_sign_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .cmp_i      (cmp),
        .dac_code_o (dac),
        .gnd_sel_o  (gnd_sel),
        .result_o   (result),
        .irq_n_o    (irq_n),
        .eoc_o      (eoc)
    );

    // behavioural comparator: ground test, or |vin| against the DAC level
    always_comb begin
        mag = (vin < 0) ? -vin : vin;
        cmp = gnd_sel ? (vin >= 0) : (mag >= int'(dac));
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int expect_result(input int v);
        int m;
        m = (v < 0) ? -v : v;
        if (m > 4095) m = 4095;
        return ((v < 0) ? 4096 : 0) + m;
    endfunction

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; vin = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 eoc", int'(eoc), 0);
        chk("R8 irq_n", int'(irq_n), 1);
        chk("R8 result", int'(result), 0);
        chk("R8 gnd_sel", int'(gnd_sel), 0);
        chk("R8 dac", int'(dac), 0);
    endtask

    // full conversion with trial-by-trial checks; pulse_at >= 0 re-requests mid-search
    task automatic t_convert(input int v, input int pulse_at);
        int m;
        int expcode;
        int old_res;
        m = (v < 0) ? -v : v;
        if (m > 4095) m = 4095;
        old_res = int'(result);
        @(negedge clk);
        vin   = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R6 eoc low", int'(eoc), 0);
        chk("R6 irq_n high", int'(irq_n), 1);
        chk("R1 gnd_sel", int'(gnd_sel), 1);
        chk("R1 dac zero", int'(dac), 0);
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            expcode = ((m >> (12 - k)) << (12 - k)) | (1 << (11 - k));
            if (k == 0) chk("R3 top trial", int'(dac), 'h800);
            else        chk("R4 trial code", int'(dac), expcode);
            chk("R1 gnd_sel off", int'(gnd_sel), 0);
            chk("R5 not done yet", int'(eoc), 0);
            chk("R7 result held", int'(result), old_res);
            start = (k == pulse_at);
        end
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R5 eoc high", int'(eoc), 1);
        chk("R5 irq_n low", int'(irq_n), 0);
        chk("R2 sign", int'(result[12]), (v < 0) ? 1 : 0);
        chk("R4 result", int'(result), expect_result(v));
    endtask

    task automatic t_idle_hold(input int v);
        int r;
        r = int'(result);
        @(negedge clk);
        vin = v;
        repeat (6) @(negedge clk);
        chk("R9 eoc held", int'(eoc), 1);
        chk("R9 irq_n held", int'(irq_n), 0);
        chk("R9 result held", int'(result), r);
        chk("R9 dac idle", int'(gnd_sel), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_convert(1234, -1);
        t_convert(-1234, -1);
        t_convert(0, -1);
        t_convert(4095, -1);
        t_convert(-4096, -1);
        t_convert(-1, -1);
        t_convert(2048, -1);
        t_convert(-2730, -1);
        t_idle_hold(-300);
        t_convert(1365, 5);
        t_convert(-77, 0);
        t_idle_hold(999);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule